// File: doc/BRIEF.md
# External Bus Cycle Sequencer with Hold Handshake

This block turns single transfer requests from a processor core into timed external bus cycles. A transfer always runs an address phase (T1) and then a strobe phase (T2). Each sampled request to wait adds one more strobe-phase clock (TW). The wait input is active high and may change at any time. It is brought into the clock domain and then read on the falling clock edge, but only while the cycle is in T2 or TW. When the cycle ends, read data is captured and a one-cycle ready pulse goes back to the core.

An external master can ask for the bus with an asynchronous hold request. The block grants it only at a cycle boundary. While the grant lasts, it withdraws all of its drivers, which are modelled as output-enable signals. When the request ends, the grant drops first. The drivers come back one clock later, and a core request that was waiting starts after that. A core request made during a hold is kept pending with ready low until the hold is over.

Top module: `xbus_cycle_ctrl`

## Requirements
- R1: While rst_n is low at a rising edge, and in the cycle after it, hold_ack=0, ads_n=rd_n=wr_n=1, core_ready=0, data_oe=0, addr_oe=1 and strobe_oe=1.
- R2: A request seen at a rising edge in idle gives T1 in the next cycle (ads_n=0) and T2 in the cycle after that (rd_n=0 for a read, wr_n=0 for a write). With no waits, core_ready is 1 in the cycle after T2.
- R3: In a read, core_rdata equals the value on bus_din at the rising edge that ends the last T2 or TW state. It is valid while core_ready is 1.
- R4: In a write, bus_addr and bus_dout carry the request's address and data from T1 onward, and data_oe is 1 from T1 through the last strobe cycle. data_oe is 0 in reads and in idle.
- R5: bus_wait (active high) passes through SYNC_STAGES rising-edge flops and is then sampled on the falling edge in T2 or TW. A sampled 1 adds one TW. If bus_wait is held high and dropped at the falling edge of the K-th strobe-low cycle, the cycle has exactly K+SYNC_STAGES strobe-low cycles.
- R6: A synchronised wait level seen only during T1 or idle has no effect: the cycle then has a single strobe-low cycle.
- R7: If no cycle is running, hold_ack rises SYNC_STAGES+1 rising edges after hold_req is driven high.
- R8: If hold_req rises during a bus cycle, hold_ack stays 0 until that cycle has given its core_ready pulse. hold_ack becomes 1 in the cycle after the ready pulse.
- R9: While hold_ack is 1, addr_oe, data_oe and strobe_oe are all 0.
- R10: hold_ack falls SYNC_STAGES+1 rising edges after hold_req drops. In that cycle the enables are still 0, and addr_oe and strobe_oe return to 1 one cycle later.
- R11: A core request made while the bus is held keeps core_ready at 0. Its T1 starts in the cycle after the one in which addr_oe returns to 1.
- R12: core_ready is 1 for exactly one cycle per transfer. A request is not accepted in the cycle in which core_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_req | input | 1 | Transfer request, held until core_ready |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | ADDR_W | Transfer address |
| core_wdata | input | DATA_W | Write data |
| core_rdata | output | DATA_W | Captured read data |
| core_ready | output | 1 | One-cycle completion pulse |
| bus_wait | input | 1 | Asynchronous wait request, active high |
| hold_req | input | 1 | Asynchronous bus hold request |
| hold_ack | output | 1 | Hold granted, bus floated |
| bus_addr | output | ADDR_W | Address bus value |
| bus_dout | output | DATA_W | Data bus value driven in writes |
| bus_din | input | DATA_W | Data bus value read back |
| addr_oe | output | 1 | Address bus drive enable |
| data_oe | output | 1 | Data bus drive enable |
| strobe_oe | output | 1 | Strobe drive enable |
| ads_n | output | 1 | Address strobe, low in T1 |
| rd_n | output | 1 | Read strobe, low in T2/TW |
| wr_n | output | 1 | Write strobe, low in T2/TW |

## Verification
The bench uses the default parameters: 16-bit address and data, and a two-stage synchroniser. Because the synchroniser depth is small, the exact latencies can be checked to the clock. These are the wait-stretch count K+2, the three-edge grant and release delays, and the case where a synchronised wait level lands in T1 but has cleared by T2. With those latencies known, the bench can raise a hold request in the middle of a stretched cycle and check the order of ready, grant, release and the first T1 of a pending request.

// File: rtl/xbus_pkg.sv
// Shared types for the external bus cycle sequencer.
package xbus_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_T1      = 3'd1,
        ST_T2      = 3'd2,
        ST_TW      = 3'd3,
        ST_HOLD    = 3'd4,
        ST_RECOVER = 3'd5
    } bus_state_e;
endpackage

// File: rtl/xbus_sync.sv
// Multi-stage synchroniser for a vector of asynchronous levels.
// Assumes each bit is an independent level; no relation between bits is kept.
module xbus_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    // Shift the asynchronous levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/xbus_wait_sampler.sv
// Falling-edge sampler for the synchronised wait level.
// Assumes sample_en is high only in strobe states; outside them the sample is cleared.
module xbus_wait_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_sync,
    input  logic sample_en,
    output logic wait_smp
);
    // Take the wait level at mid-cycle, only while a strobe state is active.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            wait_smp <= 1'b0;
        end else if (sample_en) begin
            wait_smp <= wait_sync;
        end else begin
            wait_smp <= 1'b0;
        end
    end
endmodule

// File: rtl/xbus_seq.sv
// Bus cycle state machine: T1/T2/TW sequencing, hold grant and driver recovery.
// Assumes core_req is held until core_ready and that hold_s and wait_smp are already synchronous.
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_req,
    input  logic              core_we,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    output logic [DATA_W-1:0] core_rdata,
    output logic              core_ready,
    input  logic              hold_s,
    input  logic              wait_smp,
    output logic              sample_en,
    output logic              hold_ack,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    input  logic [DATA_W-1:0] bus_din,
    output logic              addr_oe,
    output logic              data_oe,
    output logic              strobe_oe,
    output logic              ads_n,
    output logic              rd_n,
    output logic              wr_n
);
    bus_state_e st;
    logic       we_q;
    logic       in_cycle;
    logic       released;

    // State transitions, request capture and read-data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            core_ready <= 1'b0;
            core_rdata <= '0;
            bus_addr   <= '0;
            bus_dout   <= '0;
            we_q       <= 1'b0;
        end else begin
            core_ready <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (hold_s) begin
                        st <= ST_HOLD;
                    end else if (core_req && !core_ready) begin
                        st       <= ST_T1;
                        bus_addr <= core_addr;
                        bus_dout <= core_wdata;
                        we_q     <= core_we;
                    end
                end
                ST_T1: st <= ST_T2;
                ST_T2, ST_TW: begin
                    if (wait_smp) begin
                        st <= ST_TW;
                    end else begin
                        st         <= ST_IDLE;
                        core_ready <= 1'b1;
                        if (!we_q) core_rdata <= bus_din;
                    end
                end
                ST_HOLD: if (!hold_s) st <= ST_RECOVER;
                ST_RECOVER: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Decode strobes and drive enables from the current state.
    always_comb begin
        in_cycle  = (st == ST_T1) || (st == ST_T2) || (st == ST_TW);
        sample_en = (st == ST_T2) || (st == ST_TW);
        released  = (st == ST_HOLD) || (st == ST_RECOVER);
        hold_ack  = (st == ST_HOLD);
        addr_oe   = !released;
        strobe_oe = !released;
        data_oe   = in_cycle && we_q;
        ads_n     = !(st == ST_T1);
        rd_n      = !(sample_en && !we_q);
        wr_n      = !(sample_en && we_q);
    end

    assert_basic_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_T1 |=> st == ST_T2);
    assert_wait_extends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sample_en) && $past(wait_smp)) |-> st == ST_TW);
    assert_grant_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack) |-> $past(st) == ST_IDLE);
    assert_float_in_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> (!addr_oe && !strobe_oe && !data_oe));
    assert_recover_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_ack) |-> !addr_oe);
    assert_t1_after_drive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_n |-> (addr_oe && $past(addr_oe)));
    assert_ready_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        core_ready |=> !core_ready);
endmodule

// File: rtl/xbus_cycle_ctrl.sv
// Top level: synchronises wait and hold inputs, samples wait mid-cycle and runs the sequencer.
// Assumes a single clock; bus_wait and hold_req may be fully asynchronous to it.
module xbus_cycle_ctrl #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_req,
    input  logic              core_we,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    output logic [DATA_W-1:0] core_rdata,
    output logic              core_ready,
    input  logic              bus_wait,
    input  logic              hold_req,
    output logic              hold_ack,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    input  logic [DATA_W-1:0] bus_din,
    output logic              addr_oe,
    output logic              data_oe,
    output logic              strobe_oe,
    output logic              ads_n,
    output logic              rd_n,
    output logic              wr_n
);
    localparam int N_ASYNC = 2;

    logic [N_ASYNC-1:0] async_vec;
    logic [N_ASYNC-1:0] sync_vec;
    logic               wait_smp;
    logic               sample_en;

    assign async_vec = {hold_req, bus_wait};

    xbus_sync #(.STAGES(SYNC_STAGES), .WIDTH(N_ASYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(async_vec), .sync_out(sync_vec)
    );

    xbus_wait_sampler u_wsmp (
        .clk(clk), .rst_n(rst_n), .wait_sync(sync_vec[0]),
        .sample_en(sample_en), .wait_smp(wait_smp)
    );

    xbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .core_req(core_req), .core_we(core_we), .core_addr(core_addr),
        .core_wdata(core_wdata), .core_rdata(core_rdata), .core_ready(core_ready),
        .hold_s(sync_vec[1]), .wait_smp(wait_smp), .sample_en(sample_en),
        .hold_ack(hold_ack), .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_din(bus_din),
        .addr_oe(addr_oe), .data_oe(data_oe), .strobe_oe(strobe_oe),
        .ads_n(ads_n), .rd_n(rd_n), .wr_n(wr_n)
    );
endmodule

// File: tb/test_xbus_cycle_ctrl.sv
module test_xbus_cycle_ctrl;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int SS = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          core_req = 1'b0, core_we = 1'b0;
    logic [AW-1:0] core_addr = '0;
    logic [DW-1:0] core_wdata = '0, bus_din = '0;
    logic [DW-1:0] core_rdata, bus_dout;
    logic [AW-1:0] bus_addr;
    logic          core_ready, bus_wait = 1'b0, hold_req = 1'b0, hold_ack;
    logic          addr_oe, data_oe, strobe_oe, ads_n, rd_n, wr_n;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    xbus_cycle_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(SS)) i_xbus_cycle_ctrl (
        .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_we(core_we),
        .core_addr(core_addr), .core_wdata(core_wdata), .core_rdata(core_rdata),
        .core_ready(core_ready), .bus_wait(bus_wait), .hold_req(hold_req),
        .hold_ack(hold_ack), .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_din(bus_din),
        .addr_oe(addr_oe), .data_oe(data_oe), .strobe_oe(strobe_oe),
        .ads_n(ads_n), .rd_n(rd_n), .wr_n(wr_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Run a started transfer to its ready pulse, counting strobe-low cycles.
    // Drops bus_wait at the falling edge of the drop_at-th strobe cycle (0 = never).
    task automatic run_to_ready(input int drop_at, output int strobes, output bit got);
        strobes = 0;
        got = 1'b0;
        for (int i = 0; i < 60 && !got; i++) begin
            @(negedge clk);
            if (!rd_n || !wr_n) begin
                strobes++;
                if (strobes == drop_at) bus_wait = 1'b0;
            end
            if (core_ready) begin
                got = 1'b1;
                core_req = 1'b0;
            end
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(hold_ack == 0 && ads_n && rd_n && wr_n && !core_ready, "R1 strobes/ack in reset",
            {ads_n, rd_n, wr_n, hold_ack, core_ready}, 5'b11100);
        chk(addr_oe && strobe_oe && !data_oe, "R1 enables in reset",
            {addr_oe, strobe_oe, data_oe}, 3'b110);
        rst_n = 1'b1;
        @(negedge clk);
        chk(hold_ack == 0 && ads_n && rd_n && wr_n && !core_ready && !data_oe, "R1 after reset",
            {ads_n, rd_n, wr_n, hold_ack, core_ready, data_oe}, 6'b111000);
    endtask

    task automatic t_read_basic;
        core_we = 1'b0; core_addr = 16'h1234; bus_din = 16'hBEEF; core_req = 1'b1;
        @(negedge clk);
        chk(!ads_n && rd_n, "R2 T1 ads_n low", {ads_n, rd_n}, 2'b01);
        chk(bus_addr == 16'h1234, "R4 address in T1", bus_addr, 16'h1234);
        @(negedge clk);
        chk(ads_n && !rd_n && wr_n, "R2 T2 rd_n low", {ads_n, rd_n, wr_n}, 3'b101);
        chk(!data_oe, "R4 data_oe low in read", data_oe, 0);
        @(negedge clk);
        chk(core_ready && rd_n, "R2 ready after T2", {core_ready, rd_n}, 2'b11);
        chk(core_rdata == 16'hBEEF, "R3 read data captured", core_rdata, 16'hBEEF);
        core_req = 1'b0;
        @(negedge clk);
        chk(!core_ready && ads_n, "R12 ready one cycle", {core_ready, ads_n}, 2'b01);
    endtask

    task automatic t_ready_blocks_restart;
        // Keep core_req high through the ready cycle: no second T1 may follow it.
        core_we = 1'b0; bus_din = 16'h0F0F; core_req = 1'b1;
        repeat (3) @(negedge clk);
        chk(core_ready, "R12 ready seen", core_ready, 1);
        @(negedge clk);
        chk(!core_ready && ads_n, "R12 no accept in ready cycle", {core_ready, ads_n}, 2'b01);
        core_req = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_write;
        core_we = 1'b1; core_addr = 16'h0ACE; core_wdata = 16'h5A3C; core_req = 1'b1;
        @(negedge clk);
        chk(data_oe && bus_dout == 16'h5A3C, "R4 write data in T1", bus_dout, 16'h5A3C);
        chk(bus_addr == 16'h0ACE && !ads_n, "R4 write address in T1", bus_addr, 16'h0ACE);
        @(negedge clk);
        chk(!wr_n && rd_n && data_oe, "R2 T2 wr_n low", {wr_n, rd_n, data_oe}, 3'b011);
        @(negedge clk);
        chk(core_ready && !data_oe && wr_n, "R4 data_oe off after write",
            {core_ready, data_oe, wr_n}, 3'b101);
        core_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_wait_ext(input int k);
        int s; bit got;
        bus_wait = 1'b1;
        repeat (4) @(negedge clk);
        core_we = 1'b0; bus_din = 16'h7000 + 16'(k); core_req = 1'b1;
        run_to_ready(k, s, got);
        chk(got, "R5 wait cycle completes", got, 1);
        chk(s == k + SS, "R5 strobe cycles with waits", s, k + SS);
        chk(core_rdata == 16'h7000 + 16'(k), "R3 read data after waits", core_rdata, 16'h7000 + 16'(k));
        @(negedge clk);
    endtask

    task automatic t_wait_outside;
        int s; bit got;
        bus_wait = 1'b1;
        repeat (4) @(negedge clk);
        core_we = 1'b0; core_req = 1'b1; bus_wait = 1'b0;
        run_to_ready(0, s, got);
        chk(got && s == 1, "R6 wait level in T1 ignored", s, 1);
        @(negedge clk);
    endtask

    task automatic t_hold_idle;
        hold_req = 1'b1;
        for (int i = 1; i <= SS + 1; i++) begin
            @(negedge clk);
            if (i <= SS) chk(!hold_ack, "R7 no early grant", hold_ack, 0);
            else chk(hold_ack, "R7 grant latency", hold_ack, 1);
        end
        chk(!addr_oe && !strobe_oe && !data_oe, "R9 floated in hold",
            {addr_oe, strobe_oe, data_oe}, 0);
        // Request while held: must stay pending.
        core_we = 1'b0; bus_din = 16'hC0DE; core_req = 1'b1;
        repeat (3) @(negedge clk);
        chk(!core_ready && ads_n && hold_ack, "R11 request pending in hold",
            {core_ready, ads_n, hold_ack}, 3'b011);
        hold_req = 1'b0;
        for (int i = 1; i <= SS + 3; i++) begin
            @(negedge clk);
            if (i <= SS) chk(hold_ack, "R10 grant held until sync", hold_ack, 1);
            else if (i == SS + 1) chk(!hold_ack && !addr_oe && !strobe_oe, "R10 ack drops before drivers",
                {hold_ack, addr_oe, strobe_oe}, 0);
            else if (i == SS + 2) chk(addr_oe && strobe_oe && ads_n, "R11 drivers back, no T1 yet",
                {addr_oe, strobe_oe, ads_n}, 3'b111);
            else chk(!ads_n && !core_ready, "R11 pending T1 starts", {ads_n, core_ready}, 0);
        end
        repeat (2) @(negedge clk);
        chk(core_ready && core_rdata == 16'hC0DE, "R11 pending read completes", core_rdata, 16'hC0DE);
        core_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_hold_in_cycle;
        int s; bit got; bit early;
        bus_wait = 1'b1;
        repeat (4) @(negedge clk);
        core_we = 1'b1; core_wdata = 16'h1111; core_req = 1'b1;
        early = 1'b0; s = 0; got = 1'b0;
        for (int i = 0; i < 60 && !got; i++) begin
            @(negedge clk);
            if (!wr_n) begin
                s++;
                if (s == 1) hold_req = 1'b1;
                if (s == 6) bus_wait = 1'b0;
            end
            if (hold_ack) early = 1'b1;
            if (core_ready) begin got = 1'b1; core_req = 1'b0; end
        end
        chk(got && !early, "R8 cycle finishes before grant", early, 0);
        chk(s == 6 + SS, "R5 long stretch", s, 6 + SS);
        @(negedge clk);
        chk(hold_ack, "R8 grant after ready", hold_ack, 1);
        chk(!addr_oe && !data_oe && !strobe_oe, "R9 floated after in-cycle grant",
            {addr_oe, data_oe, strobe_oe}, 0);
        hold_req = 1'b0;
        repeat (SS + 2) @(negedge clk);
        chk(!hold_ack && addr_oe, "R10 released", {hold_ack, addr_oe}, 2'b01);
    endtask

    initial begin
        #(20 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_read_basic();
        t_ready_blocks_restart();
        t_write();
        t_wait_ext(1);
        t_wait_ext(3);
        t_wait_outside();
        t_hold_idle();
        t_hold_in_cycle();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule